// File: doc/BRIEF.md
# Five-Pin GPIO Controller with Status Overrides

The block drives five general-purpose pins from two byte-wide registers behind a simple write-strobe port. The direction register gives each pin its mode, either driven or sampled. Its top three bits let internal status signals take over pins 0 and 1. The data register holds the level that each driven pin puts out. When it is read, it returns the synchronized pad level for sampled pins and the stored value for driven pins.

Three status signals can take over a pin. The bus-master indication can own pin 1. The opcode-fetch indication can own pin 0. The link-connected indication can also own pin 0, for an activity LED. On pin 0 the fetch override always beats the LED override. The LED override is also held off while a configuration autoload is busy. Any pin under an override is driven, and its pull resistor is switched off. When a pin is sampled and has no override, pins 4..2 ask the pad for a pull-down and pins 1..0 ask for a pull-up.

Pin outputs, enables and pull requests come from flops: a change in a register or a status input reaches the pads at the next clock edge.

Top module: `gpio_pinmux`

## Requirements
- R1: After a synchronous reset the direction register reads 0x0F and the data register holds 0. The first clock after reset shows pin_oe = 5'b10000, pin_out = 0, pull_up = 5'b00011 and pull_dn = 5'b01100.
- R2: With no override on a pin, direction bit i = 0 makes the pin driven (pin_oe[i] = 1), and direction bit i = 1 makes it sampled (pin_oe[i] = 0). In both cases pin_out[i] equals data bit i.
- R3: A sampled pin with no override has pull_dn set for pins 4..2 and pull_up set for pins 1..0. A driven pin has neither. pull_up[4:2] and pull_dn[1:0] are always 0.
- R4: Direction bit 7 set makes pin 1 driven with the value of sts_master, whatever direction bit 1 and data bit 1 hold.
- R5: Direction bit 6 set makes pin 0 driven with the value of sts_fetch, whatever direction bit 0 and data bit 0 hold.
- R6: Direction bit 5 set, with bit 6 clear and autoload_busy low, makes pin 0 driven with the value of sts_connected.
- R7: When bit 5 is set but bit 6 is set or autoload_busy is high, the LED override is held off. Pin 0 then follows bit 6 if bit 6 is set, and otherwise follows its direction and data bits.
- R8: A pin under any override has pin_oe = 1 and both of its pull requests at 0.
- R9: Data register read bit i returns the pad level pin_in[i] through a two-flop synchronizer when direction bit i is 1. It returns stored data bit i when direction bit i is 0. Read bits 7..5 are 0.
- R10: Writes at CTRL_ADDR (default 0x00) load all 8 direction bits. Writes at DATA_ADDR (default 0x01) load data bits 4..0. Writes at any other address change nothing. Reads at any other address return 0.
- R11: rdata is combinational from addr. Pad outputs reflect register contents and status inputs one clock edge after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| pin_in | input | 5 | Pad input levels |
| pin_out | output | 5 | Pad output levels |
| pin_oe | output | 5 | Pad output enables |
| pull_up | output | 5 | Pull-up requests |
| pull_dn | output | 5 | Pull-down requests |
| sts_master | input | 1 | Internal bus-master indication |
| sts_fetch | input | 1 | Internal opcode-fetch indication |
| sts_connected | input | 1 | Internal link-connected indication |
| autoload_busy | input | 1 | Configuration autoload in progress |

## Verification
The hardest state to reach is the LED override on pin 0 being held off by fetch enable or by autoload_busy. That needs bit 5 set together with the blocker, while the direction and data bits for pin 0 differ from the status level, so that the fallback path is visible. Directed cases set each blocker on its own with opposite data and status levels. Seeded random writes then cover all eight combinations of the override bits, mixed with random status, busy and pad levels.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NPIN      = 5;
  localparam int REG_W     = 8;
  localparam int BIT_MSTR  = 7;
  localparam int BIT_FETCH = 6;
  localparam int BIT_LED   = 5;
  localparam int PIN_MSTR  = 1;
  localparam int PIN_ACT   = 0;
  localparam logic [NPIN-1:0]  UP_MASK  = 5'b00011;
  localparam logic [REG_W-1:0] DIR_RST  = 8'h0F;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 8,
  parameter int NPIN   = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 1,
  parameter logic [REG_W-1:0]  DIR_RST   = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [NPIN-1:0]   data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= DIR_RST;
      data_q <= '0;
    end else if (wr_en) begin
      if (addr == CTRL_ADDR) ctrl_q <= wdata;
      if (addr == DATA_ADDR) data_q <= wdata[NPIN-1:0];
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stg
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NPIN      = 5,
  parameter int REG_W     = 8,
  parameter int BIT_MSTR  = 7,
  parameter int BIT_FETCH = 6,
  parameter int BIT_LED   = 5,
  parameter int PIN_MSTR  = 1,
  parameter int PIN_ACT   = 0,
  parameter logic [NPIN-1:0]  UP_MASK = 5'b00011,
  parameter logic [REG_W-1:0] DIR_RST = 8'h0F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ctrl_q,
  input  logic [NPIN-1:0]  data_q,
  input  logic             sts_master,
  input  logic             sts_fetch,
  input  logic             sts_connected,
  input  logic             autoload_busy,
  output logic [NPIN-1:0]  pin_out,
  output logic [NPIN-1:0]  pin_oe,
  output logic [NPIN-1:0]  pull_up,
  output logic [NPIN-1:0]  pull_dn
);
  localparam logic [NPIN-1:0] RST_SAMPLED = ~DIR_RST[NPIN-1:0] ^ {NPIN{1'b1}};

  logic [NPIN-1:0] sampled, ovr, ovr_val;
  logic [NPIN-1:0] out_d, oe_d, up_d, dn_d;
  logic            led_live;

  assign sampled  = ctrl_q[NPIN-1:0];
  assign led_live = ctrl_q[BIT_LED] & ~ctrl_q[BIT_FETCH] & ~autoload_busy;

  always_comb begin
    ovr     = '0;
    ovr_val = '0;
    if (ctrl_q[BIT_MSTR]) begin
      ovr[PIN_MSTR]     = 1'b1;
      ovr_val[PIN_MSTR] = sts_master;
    end
    if (ctrl_q[BIT_FETCH]) begin
      ovr[PIN_ACT]     = 1'b1;
      ovr_val[PIN_ACT] = sts_fetch;
    end else if (led_live) begin
      ovr[PIN_ACT]     = 1'b1;
      ovr_val[PIN_ACT] = sts_connected;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NPIN; i++) begin : g_pin
      assign out_d[i] = ovr[i] ? ovr_val[i] : data_q[i];
      assign oe_d[i]  = ovr[i] | ~sampled[i];
      if (UP_MASK[i]) begin : g_up
        assign up_d[i] = ~oe_d[i];
        assign dn_d[i] = 1'b0;
      end else begin : g_dn
        assign up_d[i] = 1'b0;
        assign dn_d[i] = ~oe_d[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= ~RST_SAMPLED;
      pull_up <= RST_SAMPLED & UP_MASK;
      pull_dn <= RST_SAMPLED & ~UP_MASK;
    end else begin
      pin_out <= out_d;
      pin_oe  <= oe_d;
      pull_up <= up_d;
      pull_dn <= dn_d;
    end
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h01,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pull_up,
  output logic [NPIN-1:0]   pull_dn,
  input  logic              sts_master,
  input  logic              sts_fetch,
  input  logic              sts_connected,
  input  logic              autoload_busy
);
  logic [REG_W-1:0] ctrl_q;
  logic [NPIN-1:0]  data_q, pin_sync, data_view;

  gpio_regs #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .NPIN(NPIN),
    .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR), .DIR_RST(DIR_RST)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_q(ctrl_q), .data_q(data_q)
  );

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_pad_mux #(
    .NPIN(NPIN), .REG_W(REG_W), .BIT_MSTR(BIT_MSTR), .BIT_FETCH(BIT_FETCH),
    .BIT_LED(BIT_LED), .PIN_MSTR(PIN_MSTR), .PIN_ACT(PIN_ACT),
    .UP_MASK(UP_MASK), .DIR_RST(DIR_RST)
  ) mux_i (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .data_q(data_q),
    .sts_master(sts_master), .sts_fetch(sts_fetch),
    .sts_connected(sts_connected), .autoload_busy(autoload_busy),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_up(pull_up), .pull_dn(pull_dn)
  );

  assign data_view = (pin_sync & ctrl_q[NPIN-1:0]) | (data_q & ~ctrl_q[NPIN-1:0]);

  always_comb begin
    if (addr == CTRL_ADDR)      rdata = ctrl_q;
    else if (addr == DATA_ADDR) rdata = {{(REG_W-NPIN){1'b0}}, data_view};
    else                        rdata = '0;
  end
endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ctrl_q,
  input logic [4:0] pin_out,
  input logic [4:0] pin_oe,
  input logic [4:0] pull_up,
  input logic [4:0] pull_dn,
  input logic       sts_master,
  input logic       sts_fetch,
  input logic       sts_connected,
  input logic       autoload_busy
);
  // R1
  reset_oe_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == 5'b10000 && pull_up == 5'b00011 && pull_dn == 5'b01100));
  // R3
  pull_side_chk: assert property (@(posedge clk) disable iff (rst)
    (pull_up[4:2] == 3'b000 && pull_dn[1:0] == 2'b00));
  // R8
  pull_off_driven_chk: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe & (pull_up | pull_dn)) == 5'b00000));
  // R4
  master_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_q[7]) |-> (pin_oe[1] && pin_out[1] == $past(sts_master)));
  // R5
  fetch_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_q[6]) |-> (pin_oe[0] && pin_out[0] == $past(sts_fetch)));
  // R6
  led_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_q[5] && !ctrl_q[6] && !autoload_busy)
      |-> (pin_oe[0] && pin_out[0] == $past(sts_connected)));
endmodule

bind gpio_pinmux gpio_pinmux_chk chk_i (
  .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .pin_out(pin_out), .pin_oe(pin_oe),
  .pull_up(pull_up), .pull_dn(pull_dn), .sts_master(sts_master),
  .sts_fetch(sts_fetch), .sts_connected(sts_connected),
  .autoload_busy(autoload_busy)
);

// File: tb/gpio_pinmux_tb_top.sv
module gpio_pinmux_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [4:0] pin_in = 5'h00;
  logic [4:0] pin_out, pin_oe, pull_up, pull_dn;
  logic       sts_master = 1'b0, sts_fetch = 1'b0, sts_connected = 1'b0, autoload_busy = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_ctrl = 8'h0F;
  logic [4:0] m_data = 5'h00;

  always #4 clk = ~clk;

  gpio_pinmux dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pull_up(pull_up),
    .pull_dn(pull_dn), .sts_master(sts_master), .sts_fetch(sts_fetch),
    .sts_connected(sts_connected), .autoload_busy(autoload_busy)
  );

  function automatic logic [19:0] model_pads(input logic [7:0] c, input logic [4:0] d,
                                             input logic m, input logic f, input logic l,
                                             input logic b);
    logic [4:0] o, e, u, n, ov;
    o = d; e = ~c[4:0]; ov = 5'b0;
    if (c[7]) begin ov[1] = 1'b1; o[1] = m; end
    if (c[6]) begin ov[0] = 1'b1; o[0] = f; end
    else if (c[5] && !b) begin ov[0] = 1'b1; o[0] = l; end
    e = e | ov;
    u = ~e & 5'b00011;
    n = ~e & 5'b11100;
    return {o, e, u, n};
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = v;
    if (a == 8'h00) m_ctrl = v;
    if (a == 8'h01) m_data = v[4:0];
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic check_all(input string req);
    logic [19:0] x;
    repeat (3) @(negedge clk);
    x = model_pads(m_ctrl, m_data, sts_master, sts_fetch, sts_connected, autoload_busy);
    chk(req, "pin_out", {3'b0, pin_out}, {3'b0, x[19:15]});
    chk(req, "pin_oe",  {3'b0, pin_oe},  {3'b0, x[14:10]});
    chk(req, "pull_up", {3'b0, pull_up}, {3'b0, x[9:5]});
    chk(req, "pull_dn", {3'b0, pull_dn}, {3'b0, x[4:0]});
    addr = 8'h00; #1;
    chk("R10", "ctrl read", rdata, m_ctrl);
    addr = 8'h01; #1;
    chk("R9", "data read", rdata, {3'b0, (pin_in & m_ctrl[4:0]) | (m_data & ~m_ctrl[4:0])});
    addr = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0047));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "oe", {3'b0, pin_oe}, 8'h10);
    chk("R1", "out", {3'b0, pin_out}, 8'h00);
    chk("R1", "pull_up", {3'b0, pull_up}, 8'h03);
    chk("R1", "pull_dn", {3'b0, pull_dn}, 8'h0C);
    addr = 8'h00; #1; chk("R1", "ctrl", rdata, 8'h0F);
    addr = 8'h01; #1; chk("R1", "data", rdata, 8'h00);
    addr = 8'h00;

    // R11 one-edge latency after register update
    wr(8'h01, 8'h01);
    @(negedge clk); wr_en = 1'b1; addr = 8'h00; wdata = 8'h0E; m_ctrl = 8'h0E;
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk); chk("R11", "oe before", {7'b0, pin_oe[0]}, 8'h00);
    @(negedge clk); chk("R11", "oe after", {7'b0, pin_oe[0]}, 8'h01);
    chk("R2", "out0 driven", {7'b0, pin_out[0]}, 8'h01);

    // R9 synchronizer latency
    wr(8'h00, 8'h1F);
    @(negedge clk); pin_in = 5'h15; addr = 8'h01;
    @(negedge clk); chk("R9", "sync 1 edge", rdata, 8'h00);
    @(negedge clk); chk("R9", "sync 2 edges", rdata, 8'h15);
    check_all("R3");

    // R10 stray address ignored and reads zero
    wr(8'h05, 8'hE0);
    addr = 8'h05; #1; chk("R10", "stray read", rdata, 8'h00);
    check_all("R10");
    wr(8'h01, 8'hFF);
    addr = 8'h01; #1;
    check_all("R9");

    // R4, R5, R6, R7 directed
    sts_master = 1'b1; sts_fetch = 1'b0; sts_connected = 1'b1;
    wr(8'h01, 8'h00);
    wr(8'h00, 8'h83); check_all("R4");
    wr(8'h00, 8'h43); check_all("R5");
    wr(8'h00, 8'h23); check_all("R6");
    chk("R6", "pin0 led", {7'b0, pin_out[0]}, 8'h01);
    chk("R8", "pin0 no pull", {7'b0, pull_up[0]}, 8'h00);
    autoload_busy = 1'b1; check_all("R7");
    chk("R7", "busy fallback oe", {7'b0, pin_oe[0]}, 8'h00);
    chk("R7", "busy fallback pull", {7'b0, pull_up[0]}, 8'h01);
    autoload_busy = 1'b0;
    wr(8'h00, 8'h60); check_all("R7");
    chk("R7", "fetch wins", {7'b0, pin_out[0]}, 8'h00);

    // random mix
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 1) == 1) wr(8'h00, 8'($urandom));
      if ($urandom_range(0, 1) == 1) wr(8'h01, 8'($urandom));
      if ($urandom_range(0, 7) == 0) wr(8'($urandom_range(2, 255)), 8'($urandom));
      sts_master    = 1'($urandom);
      sts_fetch     = 1'($urandom);
      sts_connected = 1'($urandom);
      autoload_busy = 1'($urandom);
      pin_in        = 5'($urandom);
      check_all("R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule